// File: doc/BRIEF.md
# Watchdog Timer with Reset-Out

This block is a one-shot-armed watchdog for a small 8-bit controller. It starts disarmed after every reset. Software arms it by writing a two-byte key to a single write-only register in the special-function space. Once armed, it counts machine cycles in a 14-bit counter. The same key pair, written in time, clears the count. If the count runs out, the block raises an internal reset request and drives the external reset pin high for a fixed number of oscillator clocks. After that pulse it is disarmed again. Software has no means to disarm it.

Counting follows the core's power state. Power-down always freezes the count. After a power-down, counting resumes only once the wake-up interrupt line has gone back high. Idle freezes the count only when the halt-in-idle option is set. The external reset pin is sampled on machine-cycle strobes. When it is held high long enough, the watchdog returns to its disarmed state.

Top module: `wdt_rstout`

## Requirements
- R1: After `rst_ni` is released the watchdog is disarmed: `rst_req_o` and `rst_pin_o` stay 0 indefinitely while no key is written.
- R2: A write of 0x1E followed by a write of 0xE1 to SFR address 0xA6 arms the watchdog and clears its count. While armed, the same pair clears the count again, so periodic service prevents overflow.
- R3: While armed and running, the count advances by one on each `mc_stb_i` pulse. The overflow fires on the (2^CNT_W − 1)-th pulse after arming or service (16383 with CNT_W=14). The strobe at the clock edge that arms the block is not counted.
- R4: Once armed, no write of any value to any address disarms the watchdog. Only reset, an external reset, or its own overflow does.
- R5: The key sequence is abandoned by any write to 0xA6 other than 0xE1 that directly follows 0x1E. A write of 0x1E always (re)starts it. Writes to other addresses leave the sequence state unchanged.
- R6: On overflow `rst_req_o` is 1 for exactly PULSE_LEN (98) clocks. `rst_pin_o` follows it while `rst_out_dis_i` is 0 and is 0 whenever `rst_out_dis_i` is 1.
- R7: With `idle_halt_i`=1, `idle_i`=1 freezes the count, which resumes from the same value afterwards. With `idle_halt_i`=0, idle has no effect on counting.
- R8: `pd_i`=1 freezes the count. After `pd_i` falls, counting stays frozen until `wake_n_i` is 1.
- R9: `ext_rst_i` held 1 across EXT_MC (2) consecutive machine-cycle strobes disarms the watchdog and clears the count. A shorter high level has no effect.
- R10: A reset pulse is never shortened by `ext_rst_i`, and ends with the watchdog disarmed and the key sequence cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| mc_stb_i | input | 1 | One-clock strobe per machine cycle (every 12 clocks) |
| ext_rst_i | input | 1 | Level sampled from the external reset pin |
| sfr_we_i | input | 1 | SFR write enable |
| sfr_addr_i | input | 8 | SFR write address |
| sfr_wdata_i | input | 8 | SFR write data |
| idle_i | input | 1 | Core is in idle mode |
| pd_i | input | 1 | Core is in power-down mode |
| wake_n_i | input | 1 | Level of the external interrupt line used for wake-up (low = asserted) |
| rst_out_dis_i | input | 1 | 1 = never drive the reset pin |
| idle_halt_i | input | 1 | 1 = freeze count during idle |
| rst_req_o | output | 1 | Internal reset request, high during the overflow pulse |
| rst_pin_o | output | 1 | Drive-high enable for the reset pin |

## Verification
The embedded properties check several rules on every cycle: the pulse load and pulse end, the pin being quiet when disabled, the count freezing in power-down and halted idle, the armed state surviving all writes, foreign addresses leaving the key state alone, and the disarmed state during a pulse. The exact overflow distance, the effect of service in time, abandoned and interleaved key sequences, the wake-line hold after power-down, and the short-versus-long external reset are shown only by the bench scenarios. There, a behavioural model is compared on every clock and explicit measurements are taken.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] WDT_SFR_ADDR = 8'hA6;
  localparam logic [7:0] KEY_ARM      = 8'h1E;
  localparam logic [7:0] KEY_FIRE     = 8'hE1;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic       fire_o
);
  logic armed_q;
  logic hit;

  assign hit    = we_i && (addr_i == WDT_SFR_ADDR);
  assign fire_o = !clr_i && hit && armed_q && (wdata_i == KEY_FIRE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (clr_i)   armed_q <= 1'b0;
    else if (hit)     armed_q <= (wdata_i == KEY_ARM);
  end

  // R5
  foreign_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(we_i && addr_i == WDT_SFR_ADDR)) |=> $stable(armed_q));
  // R2
  fire_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !armed_q);
endmodule

// File: rtl/wdt_ext_rst.sv
module wdt_ext_rst #(
  parameter int EXT_MC = 2,
  localparam int EW = $clog2(EXT_MC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic block_i,
  input  logic mc_stb_i,
  input  logic ext_rst_i,
  output logic hit_o
);
  logic [EW-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          seen_q <= '0;
    else if (block_i || !ext_rst_i)       seen_q <= '0;
    else if (mc_stb_i && seen_q != EW'(EXT_MC)) seen_q <= seen_q + 1'b1;
  end

  assign hit_o = (seen_q == EW'(EXT_MC));

  // R9
  ext_hit_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(ext_rst_i));
endmodule

// File: rtl/wdt_core_cnt.sv
module wdt_core_cnt #(
  parameter int CNT_W = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic fire_i,
  input  logic mc_stb_i,
  input  logic idle_i,
  input  logic pd_i,
  input  logic wake_n_i,
  input  logic idle_halt_i,
  output logic en_o,
  output logic ovf_o
);
  localparam logic [CNT_W-1:0] LAST = {{(CNT_W-1){1'b1}}, 1'b0};

  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pd_hold_q;
  logic             run, tick;

  // count stays frozen after power-down until the wake line is back high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pd_hold_q <= 1'b0;
    else if (pd_i)     pd_hold_q <= 1'b1;
    else if (wake_n_i) pd_hold_q <= 1'b0;
  end

  assign run   = !pd_i && !pd_hold_q && !(idle_i && idle_halt_i);
  assign tick  = en_q && mc_stb_i && run;
  assign ovf_o = !clr_i && !fire_i && tick && (cnt_q == LAST);
  assign en_o  = en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (clr_i || ovf_o) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (fire_i) begin
      en_q  <= 1'b1;
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  stay_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !clr_i && !ovf_o) |=> en_q);
  // R7
  idle_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && idle_halt_i && !clr_i && !fire_i) |=> $stable(cnt_q));
  // R8
  pd_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_i && !clr_i && !fire_i) |=> $stable(cnt_q));
  // R1
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (cnt_q == '0));
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int PULSE_LEN = 98,
  localparam int PW = $clog2(PULSE_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic out_dis_i,
  output logic active_o,
  output logic pin_o
);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             left_q <= '0;
    else if (ovf_i)          left_q <= PW'(PULSE_LEN);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign active_o = (left_q != '0);
  assign pin_o    = active_o && !out_dis_i;

  // R6
  pulse_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> (left_q == PW'(PULSE_LEN)));
  // R6
  pulse_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_q == PW'(1) && !ovf_i) |=> !active_o);
  // R6
  pin_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_dis_i |-> !pin_o);
endmodule

// File: rtl/wdt_rstout.sv
module wdt_rstout #(
  parameter int CNT_W     = 14,
  parameter int PULSE_LEN = 98,
  parameter int EXT_MC    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mc_stb_i,
  input  logic       ext_rst_i,
  input  logic       sfr_we_i,
  input  logic [7:0] sfr_addr_i,
  input  logic [7:0] sfr_wdata_i,
  input  logic       idle_i,
  input  logic       pd_i,
  input  logic       wake_n_i,
  input  logic       rst_out_dis_i,
  input  logic       idle_halt_i,
  output logic       rst_req_o,
  output logic       rst_pin_o
);
  logic pulse_on, ext_hit, clr, fire, en, ovf;

  assign clr = pulse_on || ext_hit;

  wdt_key_seq u_key (
    .clk_i, .rst_ni, .clr_i(clr), .we_i(sfr_we_i),
    .addr_i(sfr_addr_i), .wdata_i(sfr_wdata_i), .fire_o(fire)
  );

  wdt_ext_rst #(.EXT_MC(EXT_MC)) u_ext (
    .clk_i, .rst_ni, .block_i(pulse_on), .mc_stb_i,
    .ext_rst_i, .hit_o(ext_hit)
  );

  wdt_core_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .clr_i(clr), .fire_i(fire), .mc_stb_i,
    .idle_i, .pd_i, .wake_n_i, .idle_halt_i, .en_o(en), .ovf_o(ovf)
  );

  wdt_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i, .rst_ni, .ovf_i(ovf), .out_dis_i(rst_out_dis_i),
    .active_o(pulse_on), .pin_o(rst_pin_o)
  );

  assign rst_req_o = pulse_on;

  // R10
  disarmed_in_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> !en);
  // R9
  ext_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_hit |=> !en);
endmodule

// File: tb/wdt_rstout_bench.sv
module wdt_rstout_bench;
  localparam int W = 6;
  localparam int LAST = (1 << W) - 1;
  localparam int PLEN = 98;

  logic clk = 0, rst_n = 0, stb = 0, ext = 0, we = 0;
  logic [7:0] addr = 0, data = 0;
  logic idle = 0, pd = 0, wake_n = 1, dis = 0, halt = 0;
  logic req, pin;

  int checks = 0, fails = 0, cyc = 0, ph = 0;
  bit done = 0, req_seen = 0;

  // behavioural model state
  int m_en = 0, m_cnt = 0, m_arm = 0, m_ext = 0, m_left = 0, m_pdh = 0;

  wdt_rstout #(.CNT_W(W)) u_wdt_rstout (
    .clk_i(clk), .rst_ni(rst_n), .mc_stb_i(stb), .ext_rst_i(ext),
    .sfr_we_i(we), .sfr_addr_i(addr), .sfr_wdata_i(data), .idle_i(idle),
    .pd_i(pd), .wake_n_i(wake_n), .rst_out_dis_i(dis), .idle_halt_i(halt),
    .rst_req_o(req), .rst_pin_o(pin)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin ph = 0; stb = 0; end
    else begin ph = (ph == 11) ? 0 : ph + 1; stb = (ph == 0); end
  end

  // model and per-clock comparison
  always @(posedge clk) begin
    bit pulse, clr, hitw, fire, run, tick, ovf;
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired R1 actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
    if (!rst_n) begin
      m_en = 0; m_cnt = 0; m_arm = 0; m_ext = 0; m_left = 0; m_pdh = 0;
    end else begin
      pulse = m_left > 0;
      clr   = pulse || m_ext >= 2;
      hitw  = we && addr == 8'hA6;
      fire  = !clr && hitw && m_arm != 0 && data == 8'hE1;
      run   = !pd && m_pdh == 0 && !(idle && halt);
      tick  = m_en != 0 && stb && run;
      ovf   = !clr && !fire && tick && m_cnt == LAST - 1;
      if (clr) m_arm = 0; else if (hitw) m_arm = (data == 8'h1E);
      if (clr || ovf) begin m_en = 0; m_cnt = 0; end
      else if (fire) begin m_en = 1; m_cnt = 0; end
      else if (tick) m_cnt++;
      if (ovf) m_left = PLEN; else if (m_left > 0) m_left--;
      if (pulse || !ext) m_ext = 0; else if (stb && m_ext < 2) m_ext++;
      if (pd) m_pdh = 1; else if (wake_n) m_pdh = 0;
    end
    #2;
    if (req) req_seen = 1;
    chk("R6 model req", int'(req), int'(m_left > 0));
    chk("R6 model pin", int'(pin), int'(m_left > 0 && !dis));
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); we = 1; addr = a; data = d;
    @(negedge clk); we = 0; addr = 0; data = 0;
  endtask

  task automatic key();
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
  endtask

  task automatic wait_mc(int n);
    int k = 0;
    while (k < n) begin @(posedge clk); #1; if (stb) k++; end
  endtask

  // strobes until request rises, then pulse width and any pin drive
  task automatic measure(int maxn, output int n, output int w, output int pin_any);
    int k = 0;
    n = -1; w = 0; pin_any = 0;
    while (k < maxn) begin
      @(posedge clk); #3;
      if (stb) k++;
      if (req) begin n = k; break; end
    end
    if (n >= 0) begin
      w = 1; pin_any = pin;
      forever begin
        @(posedge clk); #3;
        if (req) begin w++; if (pin) pin_any = 1; end else break;
      end
    end
  endtask

  initial begin
    int n, w, p;
    repeat (3) @(negedge clk);
    chk("R1 reset req", int'(req), 0);
    chk("R1 reset pin", int'(pin), 0);
    rst_n = 1;

    // R1: no key, no reset
    req_seen = 0; wait_mc(150); chk("R1 quiet unarmed", int'(req_seen), 0);

    // R2 R3 R6 R10: arm and let it overflow
    key(); measure(200, n, w, p);
    chk("R3 overflow distance", n, LAST);
    chk("R6 pulse width", w, PLEN);
    chk("R6 pin driven", p, 1);
    req_seen = 0; wait_mc(150); chk("R10 disarmed after pulse", int'(req_seen), 0);

    // R2: periodic service keeps it quiet
    key(); req_seen = 0;
    for (int i = 0; i < 5; i++) begin wait_mc(40); key(); end
    chk("R2 serviced quiet", int'(req_seen), 0);
    measure(200, n, w, p); chk("R2 overflow after last service", n, LAST);

    // R5: abandoned sequence
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h55); wr(8'hA6, 8'hE1);
    req_seen = 0; wait_mc(150); chk("R5 broken key ignored", int'(req_seen), 0);
    wr(8'hA6, 8'hE1);
    req_seen = 0; wait_mc(100); chk("R5 lone E1 ignored", int'(req_seen), 0);
    // R5: foreign address between keys keeps sequence
    wr(8'hA6, 8'h1E); wr(8'h80, 8'h00); wr(8'hA6, 8'hE1);
    measure(200, n, w, p); chk("R5 interleaved key arms", n, LAST);
    // R5: repeated arm byte restarts
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    measure(200, n, w, p); chk("R5 rearm key arms", n, LAST);

    // R4: writes cannot disarm
    key(); wr(8'hA6, 8'h00); wr(8'hA6, 8'hFF); wr(8'h80, 8'h00);
    measure(200, n, w, p); chk("R4 still armed", int'(n > 0), 1);

    // R6: pin disabled
    dis = 1; key(); measure(200, n, w, p);
    chk("R6 req with pin off", w, PLEN);
    chk("R6 pin off", p, 0);
    dis = 0;

    // R7: halt in idle
    halt = 1; key(); wait_mc(10);
    @(negedge clk); idle = 1;
    req_seen = 0; wait_mc(200); chk("R7 idle halted", int'(req_seen), 0);
    @(negedge clk); idle = 0;
    measure(200, n, w, p); chk("R7 resume remaining", n, LAST - 10);
    halt = 0; key();
    @(negedge clk); idle = 1;
    measure(200, n, w, p); chk("R7 idle counts", n, LAST);
    @(negedge clk); idle = 0;

    // R8: power-down and wake line
    key(); wait_mc(10);
    @(negedge clk); pd = 1; wake_n = 0;
    req_seen = 0; wait_mc(200); chk("R8 pd frozen", int'(req_seen), 0);
    @(negedge clk); pd = 0;
    wait_mc(200); chk("R8 wake low frozen", int'(req_seen), 0);
    @(negedge clk); wake_n = 1;
    measure(200, n, w, p); chk("R8 resume after wake", n, LAST - 10);

    // R9: long external reset disarms
    key(); wait_mc(5);
    @(negedge clk); ext = 1; wait_mc(3); @(negedge clk); ext = 0;
    req_seen = 0; wait_mc(150); chk("R9 ext reset disarms", int'(req_seen), 0);
    // R9: short external reset ignored
    key(); wait_mc(5);
    @(negedge clk); ext = 1; wait_mc(1); @(negedge clk); ext = 0;
    measure(200, n, w, p); chk("R9 short ext ignored", int'(n > 0), 1);

    // R10: ext high during pulse does not shorten it
    key(); measure(200, n, w, p);
    chk("R10 plain pulse", w, PLEN);
    key();
    n = 0;
    while (!req) begin @(posedge clk); #3; end
    @(negedge clk); ext = 1;
    w = 1;
    forever begin @(posedge clk); #3; if (req) w++; else break; end
    chk("R10 pulse with ext held", w, PLEN + 1 - 1);
    wait_mc(3); @(negedge clk); ext = 0;
    req_seen = 0; wait_mc(100); chk("R10 disarmed after", int'(req_seen), 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule